// File: doc/BRIEF.md
# ADC Input Channel Sequencer

The sequencer chooses which analog input feeds the sample/hold stage for each acquire/convert sequence of a multi-input converter. It holds two channel selections, a primary one and a secondary one. It can alternate between them on successive sequences. It can also walk the primary selection through a mask of inputs, from the lowest-numbered selected input to the highest.

A converter controller pulses `seq_done_i` when a sequence finishes. The sequencer then registers the channel for the next sequence. An internal count of completed sequences restarts the pattern once the configured number of samples per interrupt has been reached. The interrupt strobe `irq_evt_i` forces the same restart at any time. A restart returns the pattern to the primary set and to the lowest selected scan input. Converter timing and result storage belong to other blocks.

Top module: `adcseq_chan_sel`

## Requirements
- R1: While `rst` is high, and afterwards until the first strobe, `ch_sel_o` equals the first channel. The first channel is the lowest set bit of `scan_mask_i` when `scan_en_i` is 1 and the mask is non-zero. Otherwise it is `set_a_ch_i`.
- R2: With `alt_en_i` = 0 and `scan_en_i` = 0, every sequence uses `set_a_ch_i`, taking the value present at the strobe.
- R3: With `alt_en_i` = 1, the first sequence after a restart uses the primary set. The sequences then alternate: primary, `set_b_ch_i`, primary, and so on.
- R4: With `scan_en_i` = 1 and a non-zero mask, each primary-set sequence takes the next selected input above the previous scanned one (bit i of `scan_mask_i` selects input i). After the highest selected input it wraps to the lowest.
- R5: `smp_per_irq_i` holds the number of sequences per interrupt minus one. When a strobe completes sequence number `smp_per_irq_i`+1 after a restart, the pattern restarts. Selected inputs above the ones reached by then are never used.
- R6: `irq_evt_i` restarts the pattern and the sequence count on the next edge. When it arrives in the same cycle as `seq_done_i`, the restart wins.
- R7: With `scan_en_i` = 1 and an all-zero mask, primary-set sequences use `set_a_ch_i`.
- R8: With alternation and scan both enabled, secondary sequences use `set_b_ch_i`, and the scan position advances only on primary sequences.
- R9: `ch_sel_o` changes only on the edge after a strobe. Between strobes it holds its value, even when the configuration inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_a_ch_i | input | CH_W | Fixed channel of the primary set |
| set_b_ch_i | input | CH_W | Fixed channel of the secondary set |
| alt_en_i | input | 1 | Alternate primary/secondary sets |
| scan_en_i | input | 1 | Scan the primary set across the mask |
| scan_mask_i | input | NUM_INPUTS | Inputs taking part in the scan |
| smp_per_irq_i | input | CNT_W | Sequences per interrupt, minus one |
| seq_done_i | input | 1 | A sequence has completed |
| irq_evt_i | input | 1 | Interrupt event, forces a restart |
| ch_sel_o | output | CH_W | Channel for the next sequence |

## Verification
The sequence-complete strobe and the interrupt strobe can arrive in the same cycle. In that case the completed sequence would normally advance the scan or the alternation, but the restart must override it. The bench provokes this directly in the middle of a scan, where an advance would give a different channel than the restart. It also draws both strobes independently at random, so the collision occurs many times. Each time, the next registered channel is compared with the restart channel that the reference model computes, and a follow-on strobe confirms that the count restarted as well.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  typedef enum logic {PH_A = 1'b0, PH_B = 1'b1} phase_e;
endpackage

// File: rtl/adcseq_sample_cnt.sv
module adcseq_sample_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             done_i,
  input  logic             force_i,
  output logic             restart_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap      = done_i && (cnt_q == limit_i);
  assign restart_o = force_i || wrap;

  always_ff @(posedge clk) begin
    if (rst)            cnt_q <= '0;
    else if (restart_o) cnt_q <= '0;
    else if (done_i)    cnt_q <= cnt_q + 1'b1;
  end

  // R5
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (done_i && cnt_q == limit_i) |=> (cnt_q == '0));

  // R6
  force_clear_chk: assert property (@(posedge clk) disable iff (rst)
    force_i |=> (cnt_q == '0));
endmodule

// File: rtl/adcseq_scan_pick.sv
module adcseq_scan_pick #(
  parameter int NUM_INPUTS = 16,
  localparam int CH_W = $clog2(NUM_INPUTS)
) (
  input  logic [NUM_INPUTS-1:0] mask_i,
  input  logic [CH_W-1:0]       pos_i,
  output logic                  any_o,
  output logic [CH_W-1:0]       low_o,
  output logic [CH_W-1:0]       next_o
);
  logic [NUM_INPUTS-1:0] above;
  logic [CH_W-1:0]       above_low;
  logic                  above_any;

  for (genvar i = 0; i < NUM_INPUTS; i++) begin : g_above
    assign above[i] = mask_i[i] && (CH_W'(i) > pos_i);
  end

  always_comb begin
    low_o     = '0;
    above_low = '0;
    for (int i = NUM_INPUTS - 1; i >= 0; i--) begin
      if (mask_i[i]) low_o     = CH_W'(i);
      if (above[i])  above_low = CH_W'(i);
    end
  end

  assign any_o     = |mask_i;
  assign above_any = |above;
  assign next_o    = above_any ? above_low : low_o;
endmodule

// File: rtl/adcseq_chan_sel.sv
module adcseq_chan_sel
  import adcseq_pkg::*;
#(
  parameter int NUM_INPUTS = 16,
  parameter int CNT_W      = 4,
  localparam int CH_W      = $clog2(NUM_INPUTS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [CH_W-1:0]       set_a_ch_i,
  input  logic [CH_W-1:0]       set_b_ch_i,
  input  logic                  alt_en_i,
  input  logic                  scan_en_i,
  input  logic [NUM_INPUTS-1:0] scan_mask_i,
  input  logic [CNT_W-1:0]      smp_per_irq_i,
  input  logic                  seq_done_i,
  input  logic                  irq_evt_i,
  output logic [CH_W-1:0]       ch_sel_o
);
  phase_e          phase_q;
  logic [CH_W-1:0] pos_q;
  logic [CH_W-1:0] ch_q;
  logic            restart;
  logic            mask_any;
  logic [CH_W-1:0] mask_low;
  logic [CH_W-1:0] mask_next;
  logic            scan_live;
  logic [CH_W-1:0] first_ch;
  logic [CH_W-1:0] next_a_ch;
  logic            go_b;

  adcseq_sample_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk       (clk),
    .rst       (rst),
    .limit_i   (smp_per_irq_i),
    .done_i    (seq_done_i),
    .force_i   (irq_evt_i),
    .restart_o (restart)
  );

  adcseq_scan_pick #(.NUM_INPUTS(NUM_INPUTS)) i_pick (
    .mask_i (scan_mask_i),
    .pos_i  (pos_q),
    .any_o  (mask_any),
    .low_o  (mask_low),
    .next_o (mask_next)
  );

  assign scan_live = scan_en_i && mask_any;
  assign first_ch  = scan_live ? mask_low : set_a_ch_i;
  assign next_a_ch = scan_live ? mask_next : set_a_ch_i;
  assign go_b      = alt_en_i && (phase_q == PH_A);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      phase_q <= PH_A;
      pos_q   <= mask_low;
      ch_q    <= first_ch;
    end else if (seq_done_i) begin
      if (go_b) begin
        phase_q <= PH_B;
        ch_q    <= set_b_ch_i;
      end else begin
        phase_q <= PH_A;
        ch_q    <= next_a_ch;
        if (scan_live) pos_q <= mask_next;
      end
    end
  end

  assign ch_sel_o = ch_q;

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!seq_done_i && !irq_evt_i) |=> $stable(ch_sel_o));

  // R6
  irq_restart_chk: assert property (@(posedge clk) disable iff (rst)
    irq_evt_i |=> (phase_q == PH_A));

  // R3
  alt_b_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_done_i && !restart && alt_en_i && phase_q == PH_A)
      |=> (ch_sel_o == $past(set_b_ch_i)));

  // R2
  fixed_a_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_done_i && !alt_en_i && !scan_en_i) |=> (ch_sel_o == $past(set_a_ch_i)));

  // R4
  scan_member_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_done_i && !alt_en_i && scan_en_i && (|scan_mask_i))
      |=> ((($past(scan_mask_i) >> ch_sel_o) & NUM_INPUTS'(1)) != '0));

  // R8
  pos_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_done_i && !restart && go_b) |=> $stable(pos_q));
endmodule

// File: tb/test_adcseq_chan_sel.sv
`timescale 1ns/1ps
module test_adcseq_chan_sel;
  localparam int NI = 16;
  localparam int CW = 4;
  localparam int NW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] set_a = '0;
  logic [CW-1:0] set_b = '0;
  logic          alt = 1'b0;
  logic          scan = 1'b0;
  logic [NI-1:0] mask = '0;
  logic [NW-1:0] smp = '1;
  logic          sd = 1'b0;
  logic          irq = 1'b0;
  logic [CW-1:0] ch_sel;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  logic [CW-1:0] m_ch;
  logic [CW-1:0] m_pos;
  logic [NW-1:0] m_cnt;
  logic          m_b;

  always #2.5 clk = ~clk;

  adcseq_chan_sel #(.NUM_INPUTS(NI), .CNT_W(NW)) i_adcseq_chan_sel (
    .clk(clk), .rst(rst), .set_a_ch_i(set_a), .set_b_ch_i(set_b),
    .alt_en_i(alt), .scan_en_i(scan), .scan_mask_i(mask),
    .smp_per_irq_i(smp), .seq_done_i(sd), .irq_evt_i(irq), .ch_sel_o(ch_sel)
  );

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=200000", cycles);
      finish_run();
    end
  end

  function automatic logic [CW-1:0] lowest(input logic [NI-1:0] m);
    for (int i = 0; i < NI; i++) if (m[i]) return CW'(i);
    return '0;
  endfunction

  function automatic logic [CW-1:0] next_sel(input logic [NI-1:0] m, input logic [CW-1:0] p);
    for (int i = 0; i < NI; i++) if (m[i] && i > int'(p)) return CW'(i);
    return lowest(m);
  endfunction

  function automatic logic [CW-1:0] first_of();
    return (scan && mask != 0) ? lowest(mask) : set_a;
  endfunction

  task automatic model_restart();
    m_cnt = '0;
    m_b   = 1'b0;
    m_pos = lowest(mask);
    m_ch  = first_of();
  endtask

  task automatic model_step(input logic d, input logic q);
    if (q || (d && m_cnt == smp)) begin
      model_restart();
    end else if (d) begin
      m_cnt = m_cnt + 1'b1;
      if (alt && !m_b) begin
        m_b  = 1'b1;
        m_ch = set_b;
      end else begin
        m_b = 1'b0;
        if (scan && mask != 0) begin
          m_pos = next_sel(mask, m_pos);
          m_ch  = m_pos;
        end else begin
          m_ch = set_a;
        end
      end
    end
  endtask

  task automatic check(input string tag, input logic [CW-1:0] got, input logic [CW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, got, exp, cycles);
    end
  endtask

  task automatic cyc(input logic d, input logic q, input string tag);
    @(negedge clk);
    sd  = d;
    irq = q;
    @(posedge clk);
    #1;
    model_step(d, q);
    check(tag, ch_sel, m_ch);
    sd  = 1'b0;
    irq = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    model_restart();
    rst = 1'b0;
  endtask

  task automatic expect_ch(input string tag, input int exp);
    check(tag, ch_sel, CW'(exp));
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);

    // R1: reset with fixed channel, then with a scan mask
    set_a = 4'd5;
    do_reset();
    #1 expect_ch("R1", 5);
    scan = 1'b1; mask = 16'h0A30;
    do_reset();
    #1 expect_ch("R1", 4);
    cyc(1'b0, 1'b0, "R1");
    expect_ch("R1", 4);

    // R2: fixed primary channel
    scan = 1'b0; alt = 1'b0; set_a = 4'd7; smp = 4'd15;
    cyc(1'b0, 1'b1, "R2"); expect_ch("R2", 7);
    cyc(1'b1, 1'b0, "R2"); expect_ch("R2", 7);
    set_a = 4'd2;
    cyc(1'b1, 1'b0, "R2"); expect_ch("R2", 2);

    // R3: alternation A,B,A,B then restart to A
    alt = 1'b1; set_a = 4'd2; set_b = 4'd9;
    cyc(1'b0, 1'b1, "R3"); expect_ch("R3", 2);
    cyc(1'b1, 1'b0, "R3"); expect_ch("R3", 9);
    cyc(1'b1, 1'b0, "R3"); expect_ch("R3", 2);
    cyc(1'b1, 1'b0, "R3"); expect_ch("R3", 9);
    cyc(1'b0, 1'b1, "R3"); expect_ch("R3", 2);

    // R4: scan bits 1,6,12 with wrap
    alt = 1'b0; scan = 1'b1; mask = 16'h1042;
    cyc(1'b0, 1'b1, "R4"); expect_ch("R4", 1);
    cyc(1'b1, 1'b0, "R4"); expect_ch("R4", 6);
    cyc(1'b1, 1'b0, "R4"); expect_ch("R4", 12);
    cyc(1'b1, 1'b0, "R4"); expect_ch("R4", 1);

    // R5: two samples per interrupt, bits 3,5,8: 8 is never reached
    mask = 16'h0128; smp = 4'd1;
    cyc(1'b0, 1'b1, "R5"); expect_ch("R5", 3);
    cyc(1'b1, 1'b0, "R5"); expect_ch("R5", 5);
    cyc(1'b1, 1'b0, "R5"); expect_ch("R5", 3);
    cyc(1'b1, 1'b0, "R5"); expect_ch("R5", 5);
    cyc(1'b1, 1'b0, "R5"); expect_ch("R5", 3);

    // R6: interrupt together with sequence strobe mid-scan
    smp = 4'd15;
    cyc(1'b1, 1'b0, "R6"); expect_ch("R6", 5);
    cyc(1'b1, 1'b1, "R6"); expect_ch("R6", 3);
    cyc(1'b1, 1'b0, "R6"); expect_ch("R6", 5);
    smp = 4'd1;
    cyc(1'b1, 1'b0, "R6"); expect_ch("R6", 3);

    // R7: scan with empty mask falls back to primary channel
    smp = 4'd15; mask = '0; set_a = 4'd9;
    cyc(1'b0, 1'b1, "R7"); expect_ch("R7", 9);
    cyc(1'b1, 1'b0, "R7"); expect_ch("R7", 9);

    // R8: alternation plus scan over bits 0,4
    alt = 1'b1; mask = 16'h0011; set_b = 4'd11;
    cyc(1'b0, 1'b1, "R8"); expect_ch("R8", 0);
    cyc(1'b1, 1'b0, "R8"); expect_ch("R8", 11);
    cyc(1'b1, 1'b0, "R8"); expect_ch("R8", 4);
    cyc(1'b1, 1'b0, "R8"); expect_ch("R8", 11);
    cyc(1'b1, 1'b0, "R8"); expect_ch("R8", 0);

    // R9: no strobe, configuration changes, output holds
    set_b = 4'd3; mask = 16'h8000; alt = 1'b0; set_a = 4'd1;
    cyc(1'b0, 1'b0, "R9"); expect_ch("R9", 0);
    cyc(1'b0, 1'b0, "R9"); expect_ch("R9", 0);

    // constrained random against the model
    for (int n = 0; n < 4000; n++) begin
      logic d, q;
      string tag;
      if ($urandom % 20 == 0) begin
        set_a = CW'($urandom);
        set_b = CW'($urandom);
        alt   = ($urandom % 2) != 0;
        scan  = ($urandom % 3) != 0;
        mask  = ($urandom % 6 == 0) ? '0 : NI'($urandom);
        smp   = ($urandom % 4 == 0) ? NW'($urandom) : NW'($urandom % 4);
      end
      d = ($urandom % 2) != 0;
      q = ($urandom % 10) == 0;
      if (!d && !q)      tag = "R9";
      else if (q)        tag = "R6";
      else if (alt)      tag = "R3";
      else if (scan)     tag = "R4";
      else               tag = "R2";
      cyc(d, q, tag);
    end

    finish_run();
  end
endmodule